// File: doc/BRIEF.md
# Paged Codec Control Register File

This block holds the 16-bit control registers of an audio codec, as seen by a command decoder that sits behind a serial control link. Each register is selected by a 7-bit index, and only even indices carry registers. The decoder issues single-cycle write strobes with an index and a data word, and reads any index through a combinational read port. Every register has a default value that is loaded at reset. Each register also has a mask that decides which of its bits software may change. Bits outside the mask keep their default.

Two mechanisms make the map larger than a flat array. The first is a page-select register at 24h. It switches the window 60h..6Ah to a second bank of identification and sensing registers, and it hides the revision register at 6Ch when that bank is shown. The second is a key register at 70h that guards two vendor registers, 72h and 78h. They accept writes only while 70h holds ABBAh. Writing any data to index 00h returns every register to its default. The extended identity register at 28h always shows the two strapped codec-ID pins in its top bits.

Top module: `ctrl_regfile_paged`

## Requirements
- R1: After rst_n is released, reads return these defaults: 02h, 04h and 06h = 8000h; 26h = 000Fh; 3Ah = 2000h; 4Ch = 0003h; 28h = {codec_id, 14'h0205}; 6Ch = REV_CODE (0042h by default). Every other index reads 0000h.
- R2: A write stores (old & ~M) | (data & M), where M is the writable mask of the index: 02h/04h = 9F1Fh, 06h = 801Fh, 24h = 000Fh, 26h = FF00h (the lower byte is read-only status), 3Ah = FFFFh, 4Ch = 0003h, 70h = FFFFh.
- R3: A write of any data to index 00h restores every register to its default on the next clock edge, and that includes the page and the key. Index 00h itself reads 0000h.
- R4: Bits 3:0 of 24h hold the page. Only when the page equals 1 do 60h..6Ah show the page-1 registers. Their defaults are 62h = 64h = FFFFh and all others 0000h. Their masks are 60h = 00FFh, 62h = 64h = FFFFh, 66h = 001Fh, 68h = 0001h and 6Ah = 0000h. With any other page, the window reads 0000h and ignores writes.
- R5: 6Ch is a read-only revision register. It reads REV_CODE only while the page equals 0, and reads 0000h otherwise.
- R6: Writes to 72h (mask FFFFh) and 78h (mask 0001h) take effect only while 70h holds ABBAh. A write of any other value to 70h locks them again.
- R7: Bits 15:14 of 28h follow the codec_id pins at every moment. Only bits 5:4 of 28h are writable.
- R8: Odd indices and indices with no register read 0000h, and writes to them change nothing.
- R9: The read port is combinational. A write becomes visible from the clock edge that samples it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| codec_id | input | 2 | Strapped codec identity pins |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 7 | Write index |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read index |
| rd_data | output | 16 | Read data for rd_addr |

## Verification
Several behaviours are checked by assertions on every cycle. Odd indices never decode to a register. Read-only bits never move on a write. A soft reset always lands each register on its default. A blocked write to 72h leaves it unchanged. The window reads zero on any page but 1, and the strap bits of 28h always match the pins. Other behaviours only the bench's scenarios can show: the full default map, the exact masked value after each write across every index and several pages and data patterns, the sequence that locks and unlocks the vendor registers, and the timing of a write relative to a read of the same index.

// File: rtl/ctrl_regs_pkg.sv
package ctrl_regs_pkg;

    localparam int DW       = 16;
    localparam int AW       = 7;
    localparam int N_SLOTS  = 18;
    localparam int SLOT_W   = $clog2(N_SLOTS);

    typedef enum logic [1:0] {
        VIS_ANY = 2'd0,
        VIS_PG1 = 2'd1,
        VIS_PG0 = 2'd2
    } vis_e;

    localparam int SLOT_PAGE = 3;
    localparam int SLOT_EXID = 5;
    localparam int SLOT_KEY  = 8;
    localparam int SLOT_IADJ = 9;

    function automatic logic [AW-1:0] slot_addr(input int i);
        case (i)
            0:  return 7'h02;
            1:  return 7'h04;
            2:  return 7'h06;
            3:  return 7'h24;
            4:  return 7'h26;
            5:  return 7'h28;
            6:  return 7'h3A;
            7:  return 7'h4C;
            8:  return 7'h70;
            9:  return 7'h72;
            10: return 7'h78;
            11: return 7'h60;
            12: return 7'h62;
            13: return 7'h64;
            14: return 7'h66;
            15: return 7'h68;
            16: return 7'h6A;
            default: return 7'h6C;
        endcase
    endfunction

    function automatic vis_e slot_vis(input int i);
        if (i >= 11 && i <= 16) return VIS_PG1;
        if (i == 17)            return VIS_PG0;
        return VIS_ANY;
    endfunction

    function automatic logic slot_guarded(input int i);
        return (i == 9) || (i == 10);
    endfunction

    function automatic logic [DW-1:0] slot_default(input int i, input logic [DW-1:0] rev);
        case (i)
            0, 1, 2: return 16'h8000;
            4:       return 16'h000F;
            5:       return 16'h0205;
            6:       return 16'h2000;
            7:       return 16'h0003;
            12, 13:  return 16'hFFFF;
            17:      return rev;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [DW-1:0] slot_wmask(input int i);
        case (i)
            0, 1:       return 16'h9F1F;
            2:          return 16'h801F;
            3:          return 16'h000F;
            4:          return 16'hFF00;
            5:          return 16'h0030;
            6, 8, 9:    return 16'hFFFF;
            7:          return 16'h0003;
            10:         return 16'h0001;
            11:         return 16'h00FF;
            12, 13:     return 16'hFFFF;
            14:         return 16'h001F;
            15:         return 16'h0001;
            default:    return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/ctrl_addr_decode.sv
module ctrl_addr_decode
    import ctrl_regs_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic [AW-1:0]     addr,
    input  logic [PAGE_W-1:0] page,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic              guarded
);

    logic [N_SLOTS-1:0] match;

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            logic vis_ok;
            case (slot_vis(i))
                VIS_PG1: vis_ok = (page == PAGE_W'(1));
                VIS_PG0: vis_ok = (page == PAGE_W'(0));
                default: vis_ok = 1'b1;
            endcase
            match[i] = (addr == slot_addr(i)) && vis_ok;
        end
    end

    always_comb begin
        hit     = 1'b0;
        slot    = '0;
        guarded = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (match[i]) begin
                hit     = 1'b1;
                slot    = SLOT_W'(i);
                guarded = slot_guarded(i);
            end
        end
    end

    // R8: an odd index never reaches a register
    always_comb begin
        if (addr[0] === 1'b1) begin
            a_r8_odd_miss: assert (!hit);
        end
        a_r4_single_match: assert ($onehot0(match));
    end

endmodule

// File: rtl/ctrl_reg_slot.sv
module ctrl_reg_slot
    import ctrl_regs_pkg::*;
#(
    parameter logic [DW-1:0] DEFAULT_VAL = '0,
    parameter logic [DW-1:0] WMASK       = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);

    typedef struct packed {
        logic [DW-1:0] val;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.val = DEFAULT_VAL;
        end else if (we) begin
            st_d.val = (st_q.val & ~WMASK) | (wdata & WMASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= DEFAULT_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    // R3: soft reset lands on the default
    a_r3_clear_default: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == DEFAULT_VAL));

    // R2: bits outside the mask never move on a write
    a_r2_ro_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (((q ^ $past(q)) & ~WMASK) == '0));

endmodule

// File: rtl/ctrl_regfile_paged.sv
module ctrl_regfile_paged
    import ctrl_regs_pkg::*;
#(
    parameter int            PAGE_W     = 4,
    parameter logic [DW-1:0] UNLOCK_KEY = 16'hABBA,
    parameter logic [DW-1:0] REV_CODE   = 16'h0042
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    codec_id,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int ID_LSB = DW - 2;

    logic [DW-1:0]     slot_q [N_SLOTS];
    logic [PAGE_W-1:0] page_q;
    logic              unlocked;
    logic              soft_clr;

    logic              w_hit, w_guard, r_hit, r_guard;
    logic [SLOT_W-1:0] w_slot, r_slot;

    assign page_q   = slot_q[SLOT_PAGE][PAGE_W-1:0];
    assign unlocked = (slot_q[SLOT_KEY] == UNLOCK_KEY);
    assign soft_clr = wr_en && (wr_addr == '0);

    ctrl_addr_decode #(.PAGE_W(PAGE_W)) u_wdec (
        .addr    (wr_addr),
        .page    (page_q),
        .hit     (w_hit),
        .slot    (w_slot),
        .guarded (w_guard)
    );

    ctrl_addr_decode #(.PAGE_W(PAGE_W)) u_rdec (
        .addr    (rd_addr),
        .page    (page_q),
        .hit     (r_hit),
        .slot    (r_slot),
        .guarded (r_guard)
    );

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic we_i;
        assign we_i = wr_en && w_hit && (w_slot == SLOT_W'(i)) && (!w_guard || unlocked);

        ctrl_reg_slot #(
            .DEFAULT_VAL (slot_default(i, REV_CODE)),
            .WMASK       (slot_wmask(i))
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_clr),
            .we    (we_i),
            .wdata (wr_data),
            .q     (slot_q[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (r_hit) begin
            rd_data = slot_q[r_slot];
            if (r_slot == SLOT_W'(SLOT_EXID)) begin
                rd_data[DW-1:ID_LSB] = codec_id;
            end
        end
    end

    // R6: a write to 72h while locked leaves it unchanged
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h72 && slot_q[SLOT_KEY] != UNLOCK_KEY) |=> $stable(slot_q[SLOT_IADJ]));

    // R4: the paged window is blank unless page 1 is selected
    a_r4_window_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (page_q != PAGE_W'(1) && rd_addr >= 7'h60 && rd_addr <= 7'h6A) |-> (rd_data == '0));

    // R7: strap bits always follow the pins
    a_r7_strap_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 7'h28) |-> (rd_data[DW-1:ID_LSB] == codec_id));

    // R3: index 00h has no storage behind it
    a_r3_zero_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data == '0));

endmodule

// File: tb/ctrl_regfile_paged_test.sv
module ctrl_regfile_paged_test;

    localparam int            CLK_PERIOD = 10;
    localparam logic [15:0]   REV        = 16'h0042;
    localparam logic [15:0]   KEY        = 16'hABBA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  codec_id = 2'b10;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] base_m [128];
    logic [15:0] pg1_m  [128];

    ctrl_regfile_paged uut (
        .clk(clk), .rst_n(rst_n), .codec_id(codec_id),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit in_window(input logic [6:0] a);
        return (a >= 7'h60) && (a <= 7'h6A) && !a[0];
    endfunction

    function automatic logic [15:0] def_of(input logic [6:0] a);
        case (a)
            7'h02, 7'h04, 7'h06: return 16'h8000;
            7'h26: return 16'h000F;
            7'h28: return 16'h0205;
            7'h3A: return 16'h2000;
            7'h4C: return 16'h0003;
            7'h62, 7'h64: return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] mask_of(input logic [6:0] a);
        case (a)
            7'h02, 7'h04: return 16'h9F1F;
            7'h06: return 16'h801F;
            7'h24: return 16'h000F;
            7'h26: return 16'hFF00;
            7'h28: return 16'h0030;
            7'h3A, 7'h70, 7'h72, 7'h62, 7'h64: return 16'hFFFF;
            7'h4C: return 16'h0003;
            7'h78, 7'h68: return 16'h0001;
            7'h60: return 16'h00FF;
            7'h66: return 16'h001F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [6:0] a);
        if (a[0]) return "R8";
        if (a == 7'h00) return "R3";
        if (in_window(a)) return "R4";
        if (a == 7'h6C) return "R5";
        if (a == 7'h72 || a == 7'h78) return "R6";
        if (a == 7'h28) return "R7";
        if (mask_of(a) == 16'h0000) return "R8";
        return "R2";
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 128; a++) begin
            base_m[a] = in_window(7'(a)) ? 16'h0000 : def_of(7'(a));
            pg1_m[a]  = in_window(7'(a)) ? def_of(7'(a)) : 16'h0000;
        end
    endtask

    function automatic logic [15:0] expect_rd(input logic [6:0] a);
        logic [3:0] pg;
        pg = base_m[7'h24][3:0];
        if (a[0]) return 16'h0000;
        if (in_window(a)) return (pg == 4'd1) ? pg1_m[a] : 16'h0000;
        if (a == 7'h6C) return (pg == 4'd0) ? REV : 16'h0000;
        if (a == 7'h28) return {codec_id, base_m[a][13:0]};
        return base_m[a];
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [15:0] d);
        logic [15:0] m;
        m = mask_of(a);
        if (a == 7'h00) begin
            model_reset();
        end else if (a[0] || a == 7'h6C) begin
        end else if (in_window(a)) begin
            if (base_m[7'h24][3:0] == 4'd1) pg1_m[a] = (pg1_m[a] & ~m) | (d & m);
        end else if (a == 7'h72 || a == 7'h78) begin
            if (base_m[7'h70] == KEY) base_m[a] = (base_m[a] & ~m) | (d & m);
        end else begin
            base_m[a] = (base_m[a] & ~m) | (d & m);
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                         input logic [6:0] a);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s addr=%02h actual=%04h expected=%04h", tag, a, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_chk(input logic [6:0] a, input string tag);
        rd_addr = a;
        #1;
        check(tag, rd_data, expect_rd(a), a);
    endtask

    task automatic sweep(input string tag_override);
        for (int a = 0; a < 128; a++) begin
            read_chk(7'(a), (tag_override != "") ? tag_override : tag_of(7'(a)));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hA5C3; pats[1] = 16'h5A3C; pats[2] = 16'hFFFF; pats[3] = 16'h0000;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: full default map after reset, page 0
        sweep("R1");

        // R4: page 1 shows the window, hides 6Ch (R5)
        do_write(7'h24, 16'h0001);
        sweep("");

        // R2 R4 R5 R8: every index, several pages and patterns
        for (int p = 0; p < 3; p++) begin
            logic [15:0] pg;
            pg = (p == 0) ? 16'h0000 : (p == 1) ? 16'h0001 : 16'h0003;
            for (int k = 0; k < 4; k++) begin
                do_write(7'h24, pg);
                for (int a = 1; a < 128; a++) begin
                    if (a != 7'h24 && a != 7'h70) begin
                        do_write(7'(a), pats[k] ^ 16'(a));
                        read_chk(7'(a), tag_of(7'(a)));
                    end
                end
                sweep("");
            end
        end

        // R6: locked writes are dropped, key opens, other value closes
        do_write(7'h70, 16'h1234);
        do_write(7'h72, 16'h1111);
        read_chk(7'h72, "R6");
        do_write(7'h78, 16'h0001);
        read_chk(7'h78, "R6");
        do_write(7'h70, KEY);
        do_write(7'h72, 16'hBEEF);
        read_chk(7'h72, "R6");
        do_write(7'h78, 16'hFFFF);
        read_chk(7'h78, "R6");
        do_write(7'h70, 16'hABBB);
        do_write(7'h72, 16'h0000);
        read_chk(7'h72, "R6");
        read_chk(7'h70, "R2");

        // R7: strap bits follow pins live, bits 5:4 writable
        do_write(7'h28, 16'hFFFF);
        for (int id = 0; id < 4; id++) begin
            codec_id = 2'(id);
            read_chk(7'h28, "R7");
        end

        // R9: write not visible before the sampling edge, visible after
        do_write(7'h24, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h3A; wr_data = 16'h0F0F; rd_addr = 7'h3A;
        #1;
        check("R9", rd_data, expect_rd(7'h3A), 7'h3A);
        @(negedge clk);
        wr_en = 1'b0;
        model_write(7'h3A, 16'h0F0F);
        read_chk(7'h3A, "R9");

        // R3: soft reset from any data restores all, including key and page
        do_write(7'h24, 16'h0001);
        do_write(7'h70, KEY);
        do_write(7'h00, 16'h5555);
        sweep("R3");
        do_write(7'h72, 16'h7777);
        read_chk(7'h72, "R3");

        finish_run();
    end

endmodule